// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous memory with a 32-bit data word and a parameterised number of address bits. Address, control, write data and read data all pass through registers clocked on the rising edge. An access opens when one of two address strobes is sampled low. The first read word is presented one edge after the address is captured. While the advance input is held low, the next words of the aligned four-word group follow on consecutive edges. The burst order within the group is either linear or interleaved, chosen by a static select input.

A session-state machine with two states, `ST_DESEL` and `ST_SEL`, tracks whether the chip is selected. A load edge with all three select inputs valid takes the transition *select-load* to `ST_SEL`. A load edge with any select input invalid takes *deselect-load* to `ST_DESEL`. While in `ST_SEL`, an edge with no load takes either *advance* (counter +1) or *suspend* (counter held). The controller strobe always counts as a load. The processor strobe counts as a load only while chip enable is low, and a cycle loaded by it never writes. The write decision can therefore be made on any continuation edge.

The output enable acts without a clock. Any active write input also blanks the drivers during its cycle. A sleep input stops every register from updating and keeps the stored data. The drivers stop one edge after a deselecting edge, because the output stage empties one cycle after the read stage does.

Top module: `sbsram_top`

## Requirements
- R1: A low `adsc_n` at an edge is a load whatever `ce_n` is. With the chip selected it captures `addr` and starts an access. With `ce_n` high it deselects the chip.
- R2: A low `adsp_n` while `ce_n` is high is ignored. The address is not captured, the chip is not deselected, and the open access goes on unchanged.
- R3: A load selects the chip only if `ce_n`=0, `cs0`=1 and `cs1_n`=0 at that edge. Otherwise the chip is deselected and no read data is driven.
- R4: Read data for an address captured at edge k is on `dq_out` with `dq_oe` high after edge k+1.
- R5: With `linear_order`=1, beat n (n=0..3) reads the address whose two low bits are (base+n) mod 4. The upper address bits stay fixed.
- R6: With `linear_order`=0, beat n reads the address whose two low bits are base XOR n. The upper address bits stay fixed.
- R7: On a continuation edge with `adv_n` high the burst counter holds, and the same word is read again.
- R8: `gw_n`=0 writes all four byte lanes. With `gw_n`=1 and `bwe_n`=0, each `bw_n[b]`=0 writes lane b, which is bits 8b+7..8b of `dq_in`. With `bwe_n`=1, `bw_n` is ignored and the cycle reads. A write uses `dq_in` at the same edge and the address of that cycle.
- R9: A cycle loaded by `adsp_n` never writes, even with write inputs active. It is a read.
- R10: `dq_oe` is low after reset and while `oe_n` is high. Otherwise it follows the pipelined read state, so data reappears when `oe_n` returns low.
- R11: While `gw_n`=0, or while `bwe_n`=0 with any `bw_n` bit low, `dq_oe` is low in that cycle.
- R12: While `sleep` is high no register updates, `dq_oe` is low and the memory contents are kept. After `sleep` falls, the output resumes with the word held before.
- R13: After a deselecting edge k, the word read in the cycle before is still driven after edge k. `dq_oe` falls after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control and pipeline state |
| addr | input | ADDR_W | Word address captured on a load |
| adsc_n | input | 1 | Controller address strobe, active low, not gated by chip enable |
| adsp_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| cs0 | input | 1 | Chip select, active high |
| cs1_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Gate for per-lane write selects, active low |
| bw_n | input | 4 | Per-lane write selects, active low, bit b for lane b |
| oe_n | input | 1 | Asynchronous output enable, active low |
| linear_order | input | 1 | Static burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Freeze of all register updates, active high |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Registered read data |
| dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The bench builds the block with `ADDR_W`=6, a 64-word array. First it writes a distinct pattern to every word through controller-strobe global writes, so every later read has a defined expected value. The small depth keeps this fill short and leaves room for bursts that start at every low-bit offset and wrap inside their four-word group in both orders. At each edge a behavioural reference model is compared with the outputs. Hand-computed words are also checked at the beats and edges the requirements name.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic {
        ST_DESEL = 1'b0,
        ST_SEL   = 1'b1
    } sess_t;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_t;

    // Low two address bits of burst beat n within the aligned group.
    function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                           input logic [1:0] n,
                                           input logic       linear);
        return linear ? (base + n) : (base ^ n);
    endfunction

endpackage

// File: rtl/sbsram_wren.sv
module sbsram_wren #(
    parameter int BYTES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [BYTES-1:0] bw_n,
    output logic [BYTES-1:0] lane_en,
    output logic             wr_any
);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane_en[g] = !gw_n || (!bwe_n && !bw_n[g]);
    end

    assign wr_any = |lane_en;

endmodule

// File: rtl/sbsram_seq.sv
module sbsram_seq
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adsc_n,
    input  logic              adsp_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              cs0,
    input  logic              cs1_n,
    input  logic              linear,
    input  logic              wr_req,
    output logic [ADDR_W-1:0] cyc_addr,
    output cyc_t              cyc_kind
);

    localparam int HI_W = ADDR_W - 2;

    sess_t             state_q, state_d;
    logic [1:0]        cnt_q, cnt_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic              proc_ld, any_ld, sel_hit;

    // Next-state logic: select-load, deselect-load, advance, suspend.
    always_comb begin
        proc_ld = !adsp_n && !ce_n;
        any_ld  = proc_ld || !adsc_n;
        sel_hit = !ce_n && cs0 && !cs1_n;
        state_d = state_q;
        cnt_d   = cnt_q;
        base_d  = base_q;
        unique case (state_q)
            ST_DESEL: begin
                if (any_ld && sel_hit) begin
                    state_d = ST_SEL;
                    cnt_d   = 2'd0;
                    base_d  = addr;
                end
            end
            ST_SEL: begin
                if (any_ld) begin
                    state_d = sel_hit ? ST_SEL : ST_DESEL;
                    cnt_d   = 2'd0;
                    base_d  = addr;
                end else if (!adv_n) begin
                    cnt_d = cnt_q + 2'd1;
                end
            end
            default: state_d = ST_DESEL;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            cnt_q   <= '0;
            base_q  <= '0;
        end else if (run) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            base_q  <= base_d;
        end
    end

    // Outputs: address and kind of the cycle being registered at this edge.
    always_comb begin
        cyc_addr = {base_d[ADDR_W-1:2], beat_lo(base_d[1:0], cnt_d, linear)};
        if (state_d != ST_SEL)
            cyc_kind = CYC_IDLE;
        else if (wr_req && !proc_ld)
            cyc_kind = CYC_WRITE;
        else
            cyc_kind = CYC_READ;
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = base_q[ADDR_W-1:2];

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  cyc_t              cyc_kind,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [BYTES-1:0]  lane_en,
    input  logic [BYTES*8-1:0] din,
    output logic [BYTES*8-1:0] dout,
    output logic              dout_vld
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int DW    = BYTES * 8;

    logic [DW-1:0]     mem [DEPTH];
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_vld_q;

    always_ff @(posedge clk) begin
        if (run && cyc_kind == CYC_WRITE) begin
            for (int b = 0; b < BYTES; b++) begin
                if (lane_en[b])
                    mem[cyc_addr][b*8 +: 8] <= din[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr_q <= '0;
            rd_vld_q  <= 1'b0;
            dout      <= '0;
            dout_vld  <= 1'b0;
        end else if (run) begin
            rd_addr_q <= cyc_addr;
            rd_vld_q  <= (cyc_kind == CYC_READ);
            dout      <= mem[rd_addr_q];
            dout_vld  <= rd_vld_q;
        end
    end

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adsc_n,
    input  logic              adsp_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              cs0,
    input  logic              cs1_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [3:0]        bw_n,
    input  logic              oe_n,
    input  logic              linear_order,
    input  logic              sleep,
    input  logic [31:0]       dq_in,
    output logic [31:0]       dq_out,
    output logic              dq_oe
);

    localparam int BYTES = 4;

    logic              run;
    logic [BYTES-1:0]  lane_en;
    logic              wr_any;
    logic [ADDR_W-1:0] cyc_addr;
    cyc_t              cyc_kind;
    logic              dout_vld;

    assign run = !sleep;

    sbsram_wren #(.BYTES(BYTES)) u_wren (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_en (lane_en),
        .wr_any  (wr_any)
    );

    sbsram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .addr     (addr),
        .adsc_n   (adsc_n),
        .adsp_n   (adsp_n),
        .adv_n    (adv_n),
        .ce_n     (ce_n),
        .cs0      (cs0),
        .cs1_n    (cs1_n),
        .linear   (linear_order),
        .wr_req   (wr_any),
        .cyc_addr (cyc_addr),
        .cyc_kind (cyc_kind)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cyc_kind (cyc_kind),
        .cyc_addr (cyc_addr),
        .lane_en  (lane_en),
        .din      (dq_in),
        .dout     (dq_out),
        .dout_vld (dout_vld)
    );

    assign dq_oe = dout_vld && !oe_n && !sleep && !wr_any;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              adsc_n,
    input logic              adsp_n,
    input logic              adv_n,
    input logic              ce_n,
    input logic              cs0,
    input logic              cs1_n,
    input logic              gw_n,
    input logic              bwe_n,
    input logic              sess_sel,
    input logic [1:0]        cnt,
    input logic [ADDR_W-1:0] base,
    input logic              dout_vld
);

    assert_adsp_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !adsp_n && ce_n && adsc_n) |=> $stable(base));

    assert_desel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !adsc_n && (ce_n || !cs0 || cs1_n)) |=> !sess_sel);

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!sleep && !adsc_n && !ce_n && cs0 && !cs1_n && gw_n && bwe_n) ##1 !sleep)
        |=> dout_vld);

    assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && sess_sel && adsc_n && (adsp_n || ce_n) && !adv_n)
        |=> cnt == $past(cnt) + 2'd1);

    assert_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(base) && $stable(cnt) && $stable(sess_sel) && $stable(dout_vld)));

    assert_desel_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((!sleep && !adsc_n && ce_n) ##1 !sleep) |=> !dout_vld);

endmodule

bind sbsram_top sbsram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .adsc_n   (adsc_n),
    .adsp_n   (adsp_n),
    .adv_n    (adv_n),
    .ce_n     (ce_n),
    .cs0      (cs0),
    .cs1_n    (cs1_n),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .sess_sel (u_seq.state_q == sbsram_pkg::ST_SEL),
    .cnt      (u_seq.cnt_q),
    .base     (u_seq.base_q),
    .dout_vld (u_array.dout_vld)
);

// File: tb/sbsram_top_test.sv
module sbsram_top_test;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adsc_n = 1'b1, adsp_n = 1'b1, adv_n = 1'b1;
    logic          ce_n = 1'b0, cs0 = 1'b1, cs1_n = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          oe_n = 1'b0, linear_order = 1'b1, sleep = 1'b0;
    logic [31:0]   dq_in = '0;
    logic [31:0]   dq_out;
    logic          dq_oe;

    int checks = 0;
    int failures = 0;
    string phase = "R10";

    always #4 clk = ~clk;

    sbsram_top #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsc_n(adsc_n), .adsp_n(adsp_n),
        .adv_n(adv_n), .ce_n(ce_n), .cs0(cs0), .cs1_n(cs1_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .linear_order(linear_order),
        .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Behavioural reference model
    bit [31:0] m_mem [DEPTH];
    bit        m_sel, m_rdv, m_dv;
    int        m_base, m_cnt, m_rda;
    bit [31:0] m_dout;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel = 0; m_base = 0; m_cnt = 0; m_rdv = 0; m_rda = 0; m_dv = 0; m_dout = 0;
        end else if (!sleep) begin
            bit pstart, start, selok, wr;
            int a;
            bit [31:0] nxt_dout;
            bit nxt_dv;
            pstart = !adsp_n && !ce_n;
            start  = pstart || !adsc_n;
            selok  = !ce_n && cs0 && !cs1_n;
            wr     = !gw_n || (!bwe_n && bw_n != 4'hF);
            nxt_dout = m_mem[m_rda];
            nxt_dv   = m_rdv;
            if (start) begin
                m_sel = selok;
                if (selok) begin m_base = int'(addr); m_cnt = 0; end
            end else if (m_sel && !adv_n) begin
                m_cnt = (m_cnt + 1) % 4;
            end
            if (linear_order) a = (m_base & ~3) | ((m_base + m_cnt) & 3);
            else              a = (m_base & ~3) | ((m_base ^ m_cnt) & 3);
            if (m_sel && wr && !pstart) begin
                for (int b = 0; b < 4; b++)
                    if (!gw_n || (!bwe_n && !bw_n[b])) m_mem[a][b*8 +: 8] = dq_in[b*8 +: 8];
                m_rdv = 0;
            end else begin
                m_rdv = m_sel;
            end
            m_rda  = a;
            m_dout = nxt_dout;
            m_dv   = nxt_dv;
        end
    end

    function automatic logic [31:0] fill(int a);
        return {8'hC0, 8'(a), ~8'(a), 8'(a * 3)};
    endfunction

    task automatic tick();
        logic exp_oe;
        @(posedge clk);
        @(negedge clk);
        exp_oe = m_dv && !oe_n && !sleep && !(!gw_n || (!bwe_n && bw_n != 4'hF));
        checks++;
        if (dq_oe !== exp_oe) begin
            failures++;
            $display("FAIL %s model dq_oe actual=%b expected=%b t=%0t", phase, dq_oe, exp_oe, $time);
        end else if (exp_oe && dq_out !== m_dout) begin
            failures++;
            $display("FAIL %s model dq_out actual=%h expected=%h t=%0t", phase, dq_out, m_dout, $time);
        end
    endtask

    task automatic expect_word(string req, logic exp_oe, logic [31:0] exp);
        checks++;
        if (dq_oe !== exp_oe || (exp_oe && dq_out !== exp)) begin
            failures++;
            $display("FAIL %s oe=%b data=%h expected oe=%b data=%h", req, dq_oe, dq_out, exp_oe, exp);
        end
    endtask

    task automatic idle();
        adsc_n = 1; adsp_n = 1; adv_n = 1; ce_n = 0; cs0 = 1; cs1_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; sleep = 0; dq_in = '0;
    endtask

    task automatic desel();
        idle(); adsc_n = 0; ce_n = 1;
    endtask

    task automatic load_c(int a);
        idle(); adsc_n = 0; addr = AW'(a);
    endtask

    task automatic read_one(string req, int a, logic [31:0] exp);
        load_c(a); tick();
        desel();   tick(); expect_word(req, 1'b1, exp);
        idle();    tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        expect_word("R10", 1'b0, 32'h0);
        rst_n = 1;
        tick();
        expect_word("R10", 1'b0, 32'h0);

        // Fill the array with global writes (R8)
        phase = "R8";
        for (int a = 0; a < DEPTH; a++) begin
            load_c(a); gw_n = 0; dq_in = fill(a); tick();
        end
        desel(); tick();

        // Linear burst from base 6: 6,7,4,5 (R5, R4, R13)
        phase = "R5";
        linear_order = 1;
        load_c(6); tick();
        expect_word("R4", 1'b0, 32'h0);
        idle(); adv_n = 0; tick(); expect_word("R4", 1'b1, fill(6));
        tick(); expect_word("R5", 1'b1, fill(7));
        tick(); expect_word("R5", 1'b1, fill(4));
        desel(); tick(); expect_word("R13", 1'b1, fill(5));
        idle(); tick(); expect_word("R13", 1'b0, 32'h0);

        // Interleaved burst from 13 via processor strobe, write blocked (R6, R9)
        phase = "R6";
        idle(); linear_order = 0; adsp_n = 0; addr = 13; gw_n = 0; dq_in = 32'h0; tick();
        idle(); linear_order = 0; adv_n = 0; tick(); expect_word("R9", 1'b1, fill(13));
        tick(); expect_word("R6", 1'b1, fill(12));
        tick(); expect_word("R6", 1'b1, fill(15));
        desel(); linear_order = 0; tick(); expect_word("R6", 1'b1, fill(14));
        idle(); linear_order = 1; tick();

        // Suspend (R7)
        phase = "R7";
        load_c(20); tick();
        idle(); tick(); expect_word("R7", 1'b1, fill(20));
        tick(); expect_word("R7", 1'b1, fill(20));
        adv_n = 0; tick(); expect_word("R7", 1'b1, fill(20));
        desel(); tick(); expect_word("R7", 1'b1, fill(21));
        idle(); tick();

        // Byte-lane writes (R8)
        phase = "R8";
        load_c(30); bwe_n = 0; bw_n = 4'b1010; dq_in = 32'hDEADBEEF; tick();
        load_c(31); bwe_n = 1; bw_n = 4'b0000; dq_in = 32'h0; tick();
        load_c(32); gw_n = 0; bwe_n = 0; bw_n = 4'hF; dq_in = 32'h12345678; tick();
        desel(); tick(); idle(); tick();
        read_one("R8", 30, (fill(30) & 32'hFF00FF00) | (32'hDEADBEEF & 32'h00FF00FF));
        read_one("R8", 31, fill(31));
        read_one("R8", 32, 32'h12345678);

        // Processor strobe ignored with ce_n high, controller strobe not (R2, R1)
        phase = "R2";
        load_c(40); tick();
        idle(); tick(); expect_word("R1", 1'b1, fill(40));
        idle(); adsp_n = 0; ce_n = 1; addr = 50; tick(); expect_word("R2", 1'b1, fill(40));
        idle(); tick(); expect_word("R2", 1'b1, fill(40));
        phase = "R1";
        desel(); tick(); expect_word("R1", 1'b1, fill(40));
        idle(); tick(); expect_word("R1", 1'b0, 32'h0);

        // Chip select decode (R3)
        phase = "R3";
        load_c(41); tick();
        idle(); tick(); expect_word("R3", 1'b1, fill(41));
        load_c(42); cs0 = 0; tick(); expect_word("R3", 1'b1, fill(41));
        idle(); tick(); expect_word("R3", 1'b0, 32'h0);
        load_c(42); cs1_n = 1; tick(); expect_word("R3", 1'b0, 32'h0);
        idle(); tick(); expect_word("R3", 1'b0, 32'h0);
        load_c(42); tick();
        idle(); tick(); expect_word("R3", 1'b1, fill(42));

        // Output enable (R10)
        phase = "R10";
        idle(); oe_n = 1; tick(); expect_word("R10", 1'b0, 32'h0);
        idle(); tick(); expect_word("R10", 1'b1, fill(42));

        // Write input blanks outputs, continuation write (R11)
        phase = "R11";
        idle(); gw_n = 0; dq_in = 32'h0BADF00D; tick(); expect_word("R11", 1'b0, 32'h0);
        idle(); tick(); expect_word("R11", 1'b0, 32'h0);
        idle(); tick(); expect_word("R11", 1'b1, 32'h0BADF00D);

        // Sleep (R12)
        phase = "R12";
        idle(); sleep = 1; tick(); expect_word("R12", 1'b0, 32'h0);
        load_c(5); sleep = 1; gw_n = 0; dq_in = 32'hFFFFFFFF; tick(); expect_word("R12", 1'b0, 32'h0);
        load_c(9); sleep = 1; adv_n = 0; tick(); expect_word("R12", 1'b0, 32'h0);
        idle(); tick(); expect_word("R12", 1'b1, 32'h0BADF00D);
        desel(); tick(); idle(); tick();
        read_one("R12", 5, fill(5));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule